// File: doc/BRIEF.md
# Sticky Interrupt Collector

This block gathers single-cycle event pulses from several sources (for example receive almost-full, receive overflow, transmit almost-empty, transmit-empty and end-of-packet) into one active-high interrupt line. Each source has an enable bit, and one master enable bit gates all of them together. An event is kept only when its own enable and the master enable are both set. A kept event sets a flag in a pending register, and the flag stays set until the host reads that register.

The host uses a small register port. Offset 0 holds the pending flags and clears when read. Offset 1 holds the per-source enables. Offset 2 holds the master enable. The interrupt line is high while any flag is pending. A host service routine reads offset 0 once to learn every enabled event since its previous read, and that read also drops the line.

Top module: `irq_collector`

## Requirements
- R1: After reset, the pending flags, the per-source enables and the master enable are all zero, and `irq_o` is low.
- R2: Reads return, in the same cycle: the pending flags at offset 0, the enables at offset 1 (bits NUM_SRC-1:0, writable) and the master enable at offset 2 (bit 0, writable). Bits with no storage behind them read as zero.
- R3: A pulse on `evt_i[i]` while enable bit i and the master enable are both set raises pending flag i and `irq_o` after the next rising clock edge.
- R4: A pulse from a source whose enable bit is clear leaves its pending flag low. If nothing else is pending, `irq_o` stays low.
- R5: While the master enable is clear, no event sets a flag, whatever the per-source enables hold.
- R6: Once high, `irq_o` stays high through any number of idle cycles, register writes and reads of offsets 1 and 2, until offset 0 is read.
- R7: A read of offset 0 returns the pending flags and clears them. If no enabled event arrives in that cycle, `irq_o` is low on the following cycle.
- R8: An enabled event in the same cycle as a read of offset 0 is not returned by that read. It is kept for the next read, and `irq_o` stays high.
- R9: Setting a source's enable bit after its event has passed does not set that source's flag.
- R10: Flags of different sources accumulate across cycles, and one read returns all of them together.
- R11: Clearing an enable bit, or the master enable, leaves flags that are already pending unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | One-cycle event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears the flags when at offset 0) |
| addr | input | 2 | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq_o | output | 1 | Interrupt line, high while any flag is pending |

## Verification
Two operations can land in the same clock cycle: the clearing read of the pending register, and a new enabled event that must set a flag. The bench raises one flag, then issues the offset-0 read with a pulse from a different source in that same cycle. It checks three things: the read returns only the older flag, the line stays high afterwards, and a second read returns only the newer flag. Enable writes made while a flag is pending are checked in the same way, by confirming that the flag survives.

// File: rtl/irq_collector.sv
module irq_collector #(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [1:0]         addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_o
);

  localparam logic [1:0] A_PEND = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] pend_q, mask_q, hit;
  logic               master_q, rd_pend;

  assign hit     = evt_i & mask_q & {NUM_SRC{master_q}};
  assign rd_pend = rd_en && addr == A_PEND;
  assign irq_o   = |pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      mask_q   <= '0;
      master_q <= 1'b0;
    end else begin
      pend_q <= (rd_pend ? '0 : pend_q) | hit;
      if (wr_en && addr == A_MASK) mask_q   <= wdata[NUM_SRC-1:0];
      if (wr_en && addr == A_CTRL) master_q <= wdata[0];
    end
  end

  always_comb begin
    case (addr)
      A_PEND:  rdata = {{PAD_W{1'b0}}, pend_q};
      A_MASK:  rdata = {{PAD_W{1'b0}}, mask_q};
      A_CTRL:  rdata = {{(DATA_W-1){1'b0}}, master_q};
      default: rdata = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    // R4 R5 R9
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(evt_i[i] && mask_q[i] && master_q));
    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i[i] && mask_q[i] && master_q) |=> pend_q[i]);
  end

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !rd_pend) |=> irq_o);
  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && hit == '0) |=> !irq_o);
  // R8
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pend && hit != '0) |=> irq_o);

endmodule

// File: tb/test_irq_collector.sv
module test_irq_collector;
  localparam int NS = 5;
  localparam int DW = 8;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] evt_i = '0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          irq_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_collector #(.NUM_SRC(NS), .DATA_W(DW)) i_irq_collector (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [NS-1:0] ev, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1; addr = a; evt_i = ev;
    #5 d = rdata;
    @(negedge clk); rd_en = 0; evt_i = '0;
  endtask

  task automatic pulse(input logic [NS-1:0] ev);
    @(negedge clk); evt_i = ev;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    chk("R1 irq", {7'd0, irq_o}, 8'h0);
    rd(2'd0, '0, d); chk("R1 pending", d, 8'h00);
    rd(2'd1, '0, d); chk("R1 enables", d, 8'h00);
    rd(2'd2, '0, d); chk("R1 master", d, 8'h00);
  endtask

  task automatic t_regs;
    logic [DW-1:0] d;
    wr(2'd1, 8'hFF); rd(2'd1, '0, d); chk("R2 enables", d, 8'h1F);
    wr(2'd2, 8'hFF); rd(2'd2, '0, d); chk("R2 master", d, 8'h01);
    rd(2'd3, '0, d); chk("R2 unused", d, 8'h00);
  endtask

  task automatic t_enabled;
    logic [DW-1:0] d;
    wr(2'd2, 8'h01); wr(2'd1, 8'h04);
    pulse(5'h1F);
    chk("R3 irq", {7'd0, irq_o}, 8'h1);
    rd(2'd0, '0, d); chk("R3 R4 flags", d, 8'h04);
    chk("R7 irq low", {7'd0, irq_o}, 8'h0);
    pulse(5'h01);
    chk("R4 disabled irq", {7'd0, irq_o}, 8'h0);
    rd(2'd0, '0, d); chk("R4 disabled flags", d, 8'h00);
  endtask

  task automatic t_master_off;
    logic [DW-1:0] d;
    wr(2'd1, 8'h1F); wr(2'd2, 8'h00);
    pulse(5'h1F);
    chk("R5 irq", {7'd0, irq_o}, 8'h0);
    rd(2'd0, '0, d); chk("R5 flags", d, 8'h00);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_sticky;
    logic [DW-1:0] d;
    pulse(5'h01);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h1F); rd(2'd2, '0, d); rd(2'd1, '0, d);
    chk("R6 irq held", {7'd0, irq_o}, 8'h1);
    rd(2'd0, '0, d); chk("R7 read", d, 8'h01);
    chk("R7 irq low", {7'd0, irq_o}, 8'h0);
    rd(2'd0, '0, d); chk("R7 cleared", d, 8'h00);
  endtask

  task automatic t_same_cycle;
    logic [DW-1:0] d;
    pulse(5'h02);
    rd(2'd0, 5'h08, d); chk("R8 old only", d, 8'h02);
    chk("R8 irq", {7'd0, irq_o}, 8'h1);
    rd(2'd0, '0, d); chk("R8 kept", d, 8'h08);
  endtask

  task automatic t_no_retro;
    logic [DW-1:0] d;
    wr(2'd1, 8'h0F);
    pulse(5'h10);
    wr(2'd1, 8'h1F);
    chk("R9 irq", {7'd0, irq_o}, 8'h0);
    rd(2'd0, '0, d); chk("R9 flags", d, 8'h00);
  endtask

  task automatic t_accum;
    logic [DW-1:0] d;
    pulse(5'h01); pulse(5'h08); pulse(5'h10);
    rd(2'd0, '0, d); chk("R10 merged", d, 8'h19);
  endtask

  task automatic t_disable_keeps;
    logic [DW-1:0] d;
    pulse(5'h04);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    chk("R11 irq", {7'd0, irq_o}, 8'h1);
    rd(2'd0, '0, d); chk("R11 flags", d, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_regs; t_enabled; t_master_off; t_sticky;
    t_same_cycle; t_no_retro; t_accum; t_disable_keeps;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule